// File: doc/BRIEF.md
# Toggle-Based Cross-Domain Event Synchronizer

This block carries single-cycle event pulses from a source clock into a destination clock that has no fixed relation to it. On the source side, every pulse that is sampled high inverts a level register. That level is the only signal that crosses between the domains. The destination side captures the level into one register and passes it through a chain of registered change detectors. Each detector compares its input with the value it held one destination cycle earlier. When the two differ, the detector inverts its own toggle register.

The last toggle of the chain is the output. The destination logic therefore sees each event as one inversion of a level, never as a pulse. The asynchronous level is read by a single capture flop. Both the comparison and the stored history use that captured copy, so the comparison and the history cannot see two different values of the asynchronous level.

The depth of the detector chain is set by a parameter, with a default of two stages. Events must arrive at least three destination clock periods apart. If they arrive closer together, an inversion can be lost. Each domain has its own synchronous, active-high reset.

Top module: `evt_toggle_xing`

## Requirements
- R1: While either reset is asserted, and after both resets are released with no pulse applied, the output toggle reads 0.
- R2: A source clock edge with the pulse input low leaves the source-side level unchanged, and no output inversion follows from it.
- R3: A source clock edge with the pulse input high inverts the source-side level, and the output inverts exactly once for that pulse. The count of output inversions equals the count of pulses when the destination clock is faster than the source clock and when it is slower.
- R4: Each detector stage inverts its toggle one destination cycle after its input changes. With the default two stages, the output inverts within 4 destination clock edges of the source edge that sampled the pulse.
- R5: The output reports events as levels. After an output inversion, the output holds its value for at least the next destination cycle when pulses are spaced at least three destination periods apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_pulse | input | 1 | Single-cycle event request, sampled on src_clk |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_toggle | output | 1 | Level that inverts once per accepted event |

## Verification
The hardest case to reach from the ports is a train of pulses at the minimum legal spacing, where every cross-domain flip has to be captured before the next one arrives. The clock ratio decides whether such a flip lands one destination edge early or late. The bench sweeps three destination periods against the fixed source clock: one much faster, one a little slower and one far slower. These periods are unrelated, so the phase between the clocks drifts from one pulse to the next. For each period the bench sends minimum-spaced trains and widely spaced pulses. After every pulse it checks the output parity and the running inversion count.

// File: rtl/xing_pkg.sv
`timescale 1ns/1ps
package xing_pkg;
   // smallest legal number of change-detect stages after the capture flop
   localparam int unsigned XING_MIN_STAGES = 1;

   // destination edges from a source-level change to the output inversion:
   // one capture edge plus one edge per detector stage
   function automatic int unsigned xing_latency(input int unsigned stages);
      return stages + 1;
   endfunction
endpackage

// File: rtl/xing_src_flip.sv
`timescale 1ns/1ps
module xing_src_flip (
   input  logic clk,
   input  logic rst,
   input  logic pulse,
   output logic level
);
   logic level_r;

   always_ff @(posedge clk) begin
      if (rst)        level_r <= 1'b0;
      else if (pulse) level_r <= ~level_r;
   end

   assign level = level_r;

   // R2: without a pulse the crossing level stays put
   a_r2_src_hold: assert property (@(posedge clk) disable iff (rst)
      (!rst && !pulse) |=> $stable(level));
   // R3: a sampled pulse inverts the crossing level
   a_r3_src_flip: assert property (@(posedge clk) disable iff (rst)
      (!rst && pulse) |=> (level != $past(level)));
endmodule

// File: rtl/xing_flip_stage.sv
`timescale 1ns/1ps
module xing_flip_stage (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic tgl
);
   logic hist_r;
   logic tgl_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_r <= 1'b0;
         tgl_r  <= 1'b0;
      end else begin
         hist_r <= din;
         if (din != hist_r) tgl_r <= ~tgl_r;
      end
   end

   assign tgl = tgl_r;

   // R4: a change on the stage input appears as an inversion one cycle later
   a_r4_stage_follow: assert property (@(posedge clk) disable iff (rst)
      $changed(din) |=> $changed(tgl));
endmodule

// File: rtl/xing_dst_chain.sv
`timescale 1ns/1ps
module xing_dst_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_level,
   output logic tgl_out
);
   import xing_pkg::*;

   localparam int unsigned NODES = STAGES + 1;

   if (STAGES < XING_MIN_STAGES) begin : g_bad_stages
      $error("xing_dst_chain: STAGES must be at least 1");
   end

   // the single register that reads the asynchronous level
   logic cap_r;
   logic [NODES-1:0] node;

   always_ff @(posedge clk) begin
      if (rst) cap_r <= 1'b0;
      else     cap_r <= async_level;
   end

   assign node[0] = cap_r;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      xing_flip_stage u_stage (
         .clk (clk),
         .rst (rst),
         .din (node[s]),
         .tgl (node[s+1])
      );
   end

   assign tgl_out = node[NODES-1];
endmodule

// File: rtl/evt_toggle_xing.sv
`timescale 1ns/1ps
module evt_toggle_xing #(
   parameter int unsigned STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst,
   input  logic src_pulse,
   input  logic dst_clk,
   input  logic dst_rst,
   output logic dst_toggle
);
   logic src_level;

   xing_src_flip u_src (
      .clk   (src_clk),
      .rst   (src_rst),
      .pulse (src_pulse),
      .level (src_level)
   );

   xing_dst_chain #(.STAGES(STAGES)) u_dst (
      .clk         (dst_clk),
      .rst         (dst_rst),
      .async_level (src_level),
      .tgl_out     (dst_toggle)
   );

   // R5: an output inversion is a level, held for at least one more cycle
   a_r5_level_hold: assert property (@(posedge dst_clk) disable iff (dst_rst)
      $changed(dst_toggle) |=> $stable(dst_toggle));
   // R1: reset forces the output low
   a_r1_reset_low: assert property (@(posedge dst_clk)
      dst_rst |=> !dst_toggle);
endmodule

// File: tb/evt_toggle_xing_bench.sv
`timescale 1ns/1ps
module evt_toggle_xing_bench;
   logic src_clk = 1'b0;
   logic dst_clk = 1'b0;
   logic src_rst = 1'b1;
   logic dst_rst = 1'b1;
   logic src_pulse = 1'b0;
   logic dst_toggle;

   real dst_half = 3.1;
   int  total = 0;
   int  bad = 0;
   int  flips = 0;
   int  pulses = 0;
   int  flips_base = 0;
   logic last_out = 1'b0;
   logic done = 1'b0;

   always #5 src_clk = ~src_clk;
   always #(dst_half) dst_clk = ~dst_clk;

   evt_toggle_xing u_evt_toggle_xing (
      .src_clk    (src_clk),
      .src_rst    (src_rst),
      .src_pulse  (src_pulse),
      .dst_clk    (dst_clk),
      .dst_rst    (dst_rst),
      .dst_toggle (dst_toggle)
   );

   // count output inversions away from the active edge
   always @(negedge dst_clk) begin
      if (dst_rst) last_out <= 1'b0;
      else begin
         if (dst_toggle != last_out) flips <= flips + 1;
         last_out <= dst_toggle;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      src_rst = 1'b1;
      dst_rst = 1'b1;
      repeat (4) @(posedge src_clk);
      repeat (4) @(posedge dst_clk);
      @(negedge dst_clk);
      check(dst_toggle == 1'b0, "R1 reset", dst_toggle, 0);
      @(negedge src_clk); src_rst = 1'b0;
      @(negedge dst_clk); dst_rst = 1'b0;
      @(negedge dst_clk);
      flips_base = flips;
      pulses = 0;
   endtask

   task automatic send_pulse(input int gap);
      @(negedge src_clk); src_pulse = 1'b1;
      @(posedge src_clk);
      pulses++;
      @(negedge src_clk); src_pulse = 1'b0;
      repeat (4) @(posedge dst_clk);
      @(negedge dst_clk);
      check(dst_toggle == pulses[0], "R4 parity within 4 edges", dst_toggle, pulses[0]);
      check(flips - flips_base == pulses, "R3 one inversion per pulse",
            flips - flips_base, pulses);
      repeat (gap) @(negedge src_clk);
   endtask

   task automatic run_config(input real half);
      dst_half = half;
      do_reset();
      // idle: no pulses, output must stay low
      repeat (20) @(negedge dst_clk);
      check(dst_toggle == 1'b0, "R1 idle after reset", dst_toggle, 0);
      check(flips - flips_base == 0, "R2 no inversion without pulse", flips - flips_base, 0);
      // minimum-spaced train
      for (int i = 0; i < 8; i++) send_pulse(0);
      // widely spaced pulses with varied gaps
      for (int i = 0; i < 6; i++) send_pulse(3 + i * 5);
      // long quiet stretch: output holds its level
      repeat (30) @(negedge dst_clk);
      check(dst_toggle == pulses[0], "R5 level held", dst_toggle, pulses[0]);
      check(flips - flips_base == pulses, "R2 no extra inversion while idle",
            flips - flips_base, pulses);
   endtask

   initial begin
      run_config(3.1);   // destination faster than source
      run_config(7.7);   // destination slightly slower
      run_config(17.9);  // destination much slower
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule